// File: doc/BRIEF.md
# Multiprocessor-Addressed UART Receiver

This block is the receive side of a UART that shares one serial line between one master and several slaves. Every frame carries a marker that says whether it holds an address or a data byte. In 9-bit mode the marker is the ninth data bit. In 8-bit mode the marker is the stop bit. While the address filter is on, the receiver keeps only address frames and drops data frames with no trace. Software reads each address, compares it with its own, and turns the filter off once it has been picked. From then on, data frames arrive as usual.

The serial input is synchronised and sampled with a 16x baud tick. Each bit is taken at its midpoint. A small register port gives access to the block. One address is shared by the transmit holding register (written) and the receive data register (read). A status register and a control register sit at two further addresses. The baud generator and the transmit serializer sit outside the block, so the transmit holding register simply drives an output.

Register map (byte wide). Address 0 is DATA: a write loads the transmit holding register and a read returns the received byte. Address 1 is STATUS: bit0 = receive complete, bit1 = framing error, bit2 = overrun, bit3 = received ninth bit. Address 2 is CONTROL: bit0 = 9-bit mode, bit1 = address filter enable. Address 3 reads as 0.

Top module: `mpuart_rx`

## Requirements
- R1: After a synchronous reset, every register bit is 0: the received byte, all status bits, both control bits, the transmit holding output and the read data output.
- R2: A write to address 0 shows on tx_hold one cycle later. It leaves the received byte at address 0 unchanged.
- R3: A frame is made of a low start bit, then data bits LSB first, then the ninth bit (in 9-bit mode only), then the stop bit. An accepted frame loads its byte into the receive data register and sets receive complete (STATUS bit0).
- R4: While the filter (CONTROL bit1) is set, a data frame is dropped. A data frame is one with stop bit 0 in 8-bit mode, or ninth bit 0 in 9-bit mode. The received byte, receive complete and framing error all stay unchanged.
- R5: In 8-bit mode with the filter set, a frame whose stop bit is 1 is accepted as an address frame, with framing error clear.
- R6: In 8-bit mode with the filter clear, a frame with stop bit 0 is accepted and sets framing error (STATUS bit1).
- R7: In 9-bit mode (CONTROL bit0), the frame's ninth bit is latched into STATUS bit3. A ninth bit of 1 is accepted under the filter. A stop bit of 0 sets framing error.
- R8: A read of address 0 returns the received byte on reg_rdata one cycle after reg_rd, and clears receive complete.
- R9: A frame accepted while receive complete is still set overwrites the byte and sets overrun (STATUS bit2). A frame accepted with receive complete clear leaves overrun at 0.
- R10: A low pulse on the line that is no longer low at the middle of the start bit is discarded and produces no frame.
- R11: CONTROL reads back the two bits last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after reg_rd |
| tx_hold | output | 8 | Transmit holding register |

## Verification
A register read answers on reg_rdata one clock after the strobe, and a write reaches tx_hold one clock after the strobe. The bench therefore samples at the falling edge that follows the capturing rising edge. A received frame completes at the midpoint of its stop bit, plus two synchroniser stages and one register. The bench holds the line idle for 64 clocks after each stop bit before it reads any status, so every frame result has settled. The reference model predicts tx_hold every clock and predicts the register contents after every frame, read and write.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_NINTH, S_STOP, S_HOLD
  } rx_state_t;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int ST_DONE = 0;
  localparam int ST_FERR = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_B9   = 3;

  localparam int CT_NINE = 0;
  localparam int CT_FILT = 1;
endpackage

// File: rtl/mpuart_sampler.sv
module mpuart_sampler
  import mpuart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd,
  input  logic          tick,
  input  logic          nine_bit,
  output logic          frm_vld,
  output logic [DW-1:0] frm_data,
  output logic          frm_b9,
  output logic          frm_stop
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t     st;
  logic [1:0]    sync;
  logic          rx_s;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nbit;
  logic [DW-1:0] sh;
  logic          b9_r;

  assign rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      st       <= S_IDLE;
      cnt      <= '0;
      nbit     <= '0;
      sh       <= '0;
      b9_r     <= 1'b0;
      frm_vld  <= 1'b0;
      frm_data <= '0;
      frm_b9   <= 1'b0;
      frm_stop <= 1'b0;
    end else begin
      sync    <= {sync[0], rxd};
      frm_vld <= 1'b0;
      case (st)
        S_IDLE: if (tick && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            cnt  <= '0;
            nbit <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[DW-1:1]};
            nbit <= nbit + 1'b1;
            if (nbit == BW'(DW - 1)) st <= nine_bit ? S_NINTH : S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_NINTH: if (tick) begin
          if (cnt == LAST) begin
            cnt  <= '0;
            b9_r <= rx_s;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == LAST) begin
            cnt      <= '0;
            frm_vld  <= 1'b1;
            frm_data <= sh;
            frm_b9   <= nine_bit ? b9_r : 1'b0;
            frm_stop <= rx_s;
            st       <= S_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: a completed frame is reported for exactly one cycle
  p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    frm_vld |=> !frm_vld);

  // R10: a receiver sitting idle never reports a frame on the next cycle
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |=> !frm_vld);
endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs
  import mpuart_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_vld,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_b9,
  input  logic          frm_stop,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] tx_hold,
  output logic          nine_bit
);
  logic [DW-1:0] rx_data;
  logic done, ferr, ovr, b9, filt;
  logic is_addr, accept, rd_data;
  logic [DW-1:0] stat_w, ctrl_w;

  assign is_addr = nine_bit ? frm_b9 : frm_stop;
  assign accept  = frm_vld && (is_addr || !filt);
  assign rd_data = reg_rd && (reg_addr == AW'(A_DATA));

  always_comb begin
    stat_w = '0;
    stat_w[ST_DONE] = done;
    stat_w[ST_FERR] = ferr;
    stat_w[ST_OVR]  = ovr;
    stat_w[ST_B9]   = b9;
    ctrl_w = '0;
    ctrl_w[CT_NINE] = nine_bit;
    ctrl_w[CT_FILT] = filt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      tx_hold   <= '0;
      done      <= 1'b0;
      ferr      <= 1'b0;
      ovr       <= 1'b0;
      b9        <= 1'b0;
      filt      <= 1'b0;
      nine_bit  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == AW'(A_DATA)) tx_hold <= reg_wdata;
        if (reg_addr == AW'(A_CTRL)) begin
          nine_bit <= reg_wdata[CT_NINE];
          filt     <= reg_wdata[CT_FILT];
        end
      end
      if (accept) begin
        rx_data <= frm_data;
        b9      <= frm_b9;
        ferr    <= !frm_stop;
        ovr     <= done;
        done    <= 1'b1;
      end else if (rd_data) begin
        done <= 1'b0;
      end
      if (reg_rd) begin
        case (reg_addr)
          AW'(A_DATA): reg_rdata <= rx_data;
          AW'(A_STAT): reg_rdata <= stat_w;
          AW'(A_CTRL): reg_rdata <= ctrl_w;
          default:     reg_rdata <= '0;
        endcase
      end
    end
  end

  // R4: a filtered data frame leaves byte and flags untouched
  p_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && filt && !is_addr && !rd_data) |=>
      ($stable(rx_data) && $stable(done) && $stable(ferr)));

  // R3: an accepted frame lands in the receive register with complete set
  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (done && rx_data == $past(frm_data)));

  // R8: reading the byte clears receive complete
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !accept) |=> !done);

  // R9: overrun follows a frame accepted on top of an unread one
  p_ovr_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && done) |=> ovr);

  // R2: a data write reaches the transmit holding output
  p_tx_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(A_DATA)) |=> tx_hold == $past(reg_wdata));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxd,
  input  logic          baud_tick,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] tx_hold
);
  logic          frm_vld, frm_b9, frm_stop, nine_bit;
  logic [DW-1:0] frm_data;

  mpuart_sampler #(.OSR(OSR), .DW(DW)) u_smp (
    .clk(clk), .rst(rst), .rxd(rxd), .tick(baud_tick), .nine_bit(nine_bit),
    .frm_vld(frm_vld), .frm_data(frm_data), .frm_b9(frm_b9), .frm_stop(frm_stop)
  );

  mpuart_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_data(frm_data),
    .frm_b9(frm_b9), .frm_stop(frm_stop), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_hold(tx_hold), .nine_bit(nine_bit)
  );
endmodule

// File: tb/sim_mpuart_rx.sv
`timescale 1ns/1ps
module sim_mpuart_rx;
  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1, baud_tick = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, tx_hold;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // reference model state
  logic [7:0] m_rx = 0, m_tx = 0;
  bit m_done = 0, m_ferr = 0, m_ovr = 0, m_b9 = 0, m_nine = 0, m_filt = 0;

  always #5 clk = ~clk;

  mpuart_rx u0 (
    .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_hold(tx_hold)
  );

  // 16x tick on every second clock
  always @(posedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the transmit holding output (R2)
  always begin
    @(posedge clk); #3;
    if (!rst && !done_flag) check(tx_hold == m_tx, "R2 tx_hold", tx_hold, m_tx);
  end

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    if (a == 2'd0) m_done = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    if (a == 2'd0) m_tx = v;
    if (a == 2'd2) begin m_nine = v[0]; m_filt = v[1]; end
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic line_bit(input bit b);
    rxd = b;
    repeat (32) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit b9, input bit stp);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    if (m_nine) line_bit(b9);
    line_bit(stp);
    rxd = 1'b1;
    repeat (64) @(posedge clk);
    if ((m_nine ? b9 : stp) || !m_filt) begin
      m_rx = d; m_b9 = m_nine ? b9 : 1'b0; m_ferr = !stp;
      m_ovr = m_done; m_done = 1;
    end
  endtask

  task automatic chk_stat(input string tag);
    logic [7:0] v, e;
    rd(2'd1, v);
    e = {4'b0, m_b9, m_ovr, m_ferr, m_done};
    check(v == e, tag, v, e);
  endtask

  task automatic chk_data(input string tag);
    logic [7:0] v, e;
    e = m_rx;
    rd(2'd0, v);
    check(v == e, tag, v, e);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check(reg_rdata == 0 && tx_hold == 0, "R1 outputs", {reg_rdata, tx_hold}, 0);
    chk_stat("R1 status");
    rd(2'd2, v); check(v == 0, "R1 control", v, 0);
    chk_data("R1 data");
    // R11 control readback, 8-bit filtered
    wr(2'd2, 8'h02);
    rd(2'd2, v); check(v == 8'h02, "R11 control", v, 8'h02);
    // R5/R3 address frame accepted under filter
    send(8'hA5, 1'b0, 1'b1);
    chk_stat("R5 addr status");
    chk_data("R3 addr byte");
    chk_stat("R8 done cleared by read");
    // R4 data frame dropped in 8-bit mode
    send(8'h3C, 1'b0, 1'b0);
    chk_stat("R4 8-bit drop status");
    chk_data("R4 8-bit drop byte");
    // R6 filter off, data frame with framing error
    wr(2'd2, 8'h00);
    send(8'h3C, 1'b0, 1'b0);
    chk_stat("R6 data status");
    chk_data("R6 data byte");
    // R9 overrun
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    chk_stat("R9 overrun set");
    chk_data("R9 overwritten byte");
    send(8'h33, 1'b0, 1'b1);
    chk_stat("R9 overrun cleared");
    chk_data("R3 byte 33");
    // R7 9-bit mode with filter
    wr(2'd2, 8'h03);
    rd(2'd2, v); check(v == 8'h03, "R11 control 9-bit", v, 8'h03);
    send(8'h5A, 1'b0, 1'b1);
    chk_stat("R4 9-bit drop status");
    chk_data("R4 9-bit drop byte");
    send(8'h81, 1'b1, 1'b1);
    chk_stat("R7 addr ninth bit");
    chk_data("R7 addr byte");
    wr(2'd2, 8'h01);
    send(8'h7E, 1'b0, 1'b1);
    chk_stat("R7 data ninth bit");
    chk_data("R7 data byte");
    send(8'h42, 1'b0, 1'b0);
    chk_stat("R7 framing error");
    chk_data("R7 byte 42");
    // R10 start glitch
    wr(2'd2, 8'h00);
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(posedge clk);
    rxd = 1'b1;
    repeat (400) @(posedge clk);
    chk_stat("R10 glitch ignored");
    send(8'hC3, 1'b0, 1'b1);
    chk_stat("R10 frame after glitch");
    // R2 write does not disturb receive byte
    wr(2'd0, 8'h96);
    chk_data("R2 rx byte after tx write");
    wr(2'd0, 8'h69);
    repeat (3) @(posedge clk);
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done_flag = 1;
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule